// File: doc/BRIEF.md
# Sync-Clocked Monitor ID Byte Sender

This block sends monitor identification bytes to a display host over a one-way serial link. Software queues bytes into an eight-entry byte queue. The host's clock line acts as a gate. While that line is high, every rising edge on the vertical sync input moves one bit onto the serial data output. Each byte goes out as a nine-bit frame: eight data bits, most significant first, and then a separator bit that is always 1. When the queue is empty at the start of a frame, the data line stays high until a byte arrives.

Both asynchronous inputs pass through two-flop synchronisers, and edges are detected after synchronisation. Two watermark flags report the queue state. The low flag compares the fill level with a threshold of 1 to 4 set by a two-bit select. When enabled, it also raises an interrupt request. The high flag shows that the queue is full.

An auto-load mode removes the per-byte software write. While it is on, every read strobe on the memory-buffer data port also queues the byte being read. This transmit mode is the default after reset.

Top module: `ddc1_tx_fifo`

## Requirements
- R1: After reset, `sda_out` is 1, the queue is empty, `low_flag` is 1, `high_flag` is 0 and `low_irq` equals `low_irq_en`.
- R2: Vertical sync rising edges seen while the synchronised `host_clk_in` is low leave `sda_out` and the queue unchanged.
- R3: A qualified vertical sync rising edge drives the next bit of a nine-bit frame. The frame is the data byte, most significant bit first, followed by a 1. The new bit appears on the second clock edge after the edge that first samples `vsync_in` high.
- R4: If the queue is empty when a frame would start, `sda_out` is driven to 1 and the frame start is retried on the next qualified edge.
- R5: A byte leaves the queue at the qualified edge that starts its frame, and from then on it no longer counts toward the fill level.
- R6: The queue holds 8 bytes. A push made while 8 bytes are held is dropped.
- R7: `low_flag` is 1 exactly when the fill level is below `low_sel`+1 (`low_sel` 0..3 gives a threshold of 1..4).
- R8: `low_irq` is `low_flag` gated by `low_irq_en`. When the enable is 0, the request is 0.
- R9: `high_flag` is 1 exactly when more than 7 bytes are queued.
- R10: With `autoload_en` at 1, a `mbuf_rd` strobe pushes `mbuf_data`. With `autoload_en` at 0, the strobe is ignored.
- R11: When `wr_en` and an auto-load read occur in the same cycle, `wr_data` is queued and the read byte is dropped.
- R12: Bytes are transmitted in the order in which they were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_in | input | 1 | Vertical sync, used as the bit clock (asynchronous) |
| host_clk_in | input | 1 | Host clock line level, gates transmission (asynchronous) |
| wr_en | input | 1 | Software byte write strobe |
| wr_data | input | 8 | Byte to queue on a write |
| mbuf_rd | input | 1 | Software read strobe of the memory-buffer data port |
| mbuf_data | input | 8 | Byte being read from the memory buffer |
| autoload_en | input | 1 | Queue each memory-buffer read automatically |
| low_sel | input | 2 | Low-watermark select, threshold = value + 1 |
| low_irq_en | input | 1 | Low-watermark interrupt enable |
| sda_out | output | 1 | Serial data line |
| low_flag | output | 1 | Fill level below the threshold |
| high_flag | output | 1 | More than 7 bytes queued |
| low_irq | output | 1 | Low-watermark interrupt request |

## Verification
The transmitter is tried with several patterns. A short burst of distinct bytes separates MSB-first order from LSB-first order and confirms the trailing 1. Sync edges arriving with the host line low must leave the line and the queue untouched. More edges than there are bytes show the idle-high behaviour and the retried frame start. A fill past capacity shows that the ninth byte is dropped while the first eight still leave in order. The watermark flags are followed through all four threshold selects during a drain. Auto-load reads are issued with the mode on, with it off, and colliding with a write, which separates pushes that are accepted from pushes that are dropped.

// File: rtl/ddc1_pkg.sv
package ddc1_pkg;

  typedef enum logic {SH_IDLE = 1'b0, SH_BUSY = 1'b1} shift_state_e;

  // Low watermark: fill level strictly below the selected threshold (sel+1).
  function automatic logic below_mark(input int fill, input int sel);
    return fill < (sel + 1);
  endfunction

  // High watermark: more than depth-1 entries held.
  function automatic logic above_mark(input int fill, input int depth);
    return fill > (depth - 1);
  endfunction

  // Next fill level after an accepted push and/or a pop.
  function automatic int next_fill(input int fill, input logic push_ok, input logic pop);
    return fill + (push_ok ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/ddc1_sync.sv
module ddc1_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ddc1_byte_fifo.sv
module ddc1_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  fill,
  output logic              empty
);
  import ddc1_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push_ok;

  assign push_ok   = push_req && (int'(fill) < DEPTH);
  assign empty     = (fill == '0);
  assign head_data = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop)     rd_ptr <= bump(rd_ptr);
      fill <= CNT_W'(next_fill(int'(fill), push_ok, pop));
    end
  end

  a_r6_full_drops_push: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill) == DEPTH && push_req && !pop) |=> (int'(fill) == DEPTH));
  a_r6_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);
  a_r5_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/ddc1_frame_shifter.sv
module ddc1_frame_shifter #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_head,
  output logic              pop,
  output logic              sda
);
  import ddc1_pkg::*;

  shift_state_e      state;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  bits_sent;
  logic              frame_end;
  logic              idle_fill;

  assign pop       = bit_tick && (state == SH_IDLE) && !q_empty;
  assign frame_end = bit_tick && (state == SH_BUSY) && (int'(bits_sent) == DATA_W);
  assign idle_fill = bit_tick && (state == SH_IDLE) && q_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SH_IDLE;
      shreg     <= '0;
      bits_sent <= '0;
      sda       <= 1'b1;
    end else if (bit_tick) begin
      if (state == SH_IDLE) begin
        if (!q_empty) begin
          sda       <= q_head[DATA_W-1];
          shreg     <= q_head << 1;
          bits_sent <= IDX_W'(1);
          state     <= SH_BUSY;
        end else begin
          sda <= 1'b1;
        end
      end else if (int'(bits_sent) == DATA_W) begin
        sda   <= 1'b1;
        state <= SH_IDLE;
      end else begin
        sda       <= shreg[DATA_W-1];
        shreg     <= shreg << 1;
        bits_sent <= bits_sent + 1'b1;
      end
    end
  end

  a_r3_separator_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> sda);
  a_r4_empty_start_idles_high: assert property (@(posedge clk) disable iff (!rst_n)
    idle_fill |=> (sda && state == SH_IDLE));
  a_r3_quiet_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(sda));
endmodule

// File: rtl/ddc1_tx_fifo.sv
module ddc1_tx_fifo #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 8,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_in,
  input  logic              host_clk_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mbuf_rd,
  input  logic [DATA_W-1:0] mbuf_data,
  input  logic              autoload_en,
  input  logic [SEL_W-1:0]  low_sel,
  input  logic              low_irq_en,
  output logic              sda_out,
  output logic              low_flag,
  output logic              high_flag,
  output logic              low_irq
);
  import ddc1_pkg::*;

  logic              vs_sync, vs_prev, hc_sync;
  logic              vs_rise, bit_tick;
  logic              push_req, pop;
  logic [DATA_W-1:0] push_data, head_data;
  logic [CNT_W-1:0]  fill;
  logic              q_empty;

  ddc1_sync #(.STAGES(SYNC_STAGES)) u_vs_sync (
    .clk(clk), .rst_n(rst_n), .async_in(vsync_in), .sync_out(vs_sync));
  ddc1_sync #(.STAGES(SYNC_STAGES)) u_hc_sync (
    .clk(clk), .rst_n(rst_n), .async_in(host_clk_in), .sync_out(hc_sync));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_prev <= 1'b0;
    else        vs_prev <= vs_sync;
  end

  assign vs_rise  = vs_sync && !vs_prev;
  assign bit_tick = vs_rise && hc_sync;

  // Software write takes priority; an auto-load read in the same cycle is dropped.
  assign push_req  = wr_en || (autoload_en && mbuf_rd);
  assign push_data = wr_en ? wr_data : mbuf_data;

  ddc1_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
    .pop(pop), .head_data(head_data), .fill(fill), .empty(q_empty));

  ddc1_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .q_empty(q_empty),
    .q_head(head_data), .pop(pop), .sda(sda_out));

  assign low_flag  = below_mark(int'(fill), int'(low_sel));
  assign high_flag = above_mark(int'(fill), DEPTH);
  assign low_irq   = low_flag && low_irq_en;

  a_r2_host_low_holds_line: assert property (@(posedge clk) disable iff (!rst_n)
    !hc_sync |=> $stable(sda_out));
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !low_irq_en |-> !low_irq);
  a_r9_full_not_low: assert property (@(posedge clk) disable iff (!rst_n)
    high_flag |-> !low_flag);
  a_r5_pop_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (vs_rise && hc_sync));
endmodule

// File: tb/tb_ddc1_tx_fifo.sv
module tb_ddc1_tx_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync_in = 1'b0, host_clk_in = 1'b0;
  logic wr_en = 1'b0, mbuf_rd = 1'b0, autoload_en = 1'b0, low_irq_en = 1'b0;
  logic [7:0] wr_data = '0, mbuf_data = '0;
  logic [1:0] low_sel = '0;
  logic sda_out, low_flag, high_flag, low_irq;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ddc1_tx_fifo dut (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .host_clk_in(host_clk_in),
    .wr_en(wr_en), .wr_data(wr_data), .mbuf_rd(mbuf_rd), .mbuf_data(mbuf_data),
    .autoload_en(autoload_en), .low_sel(low_sel), .low_irq_en(low_irq_en),
    .sda_out(sda_out), .low_flag(low_flag), .high_flag(high_flag), .low_irq(low_irq));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: byte queue, pending-bit queue, delayed input copies.
  byte unsigned q[$];
  bit bits[$];
  bit m_sda = 1;
  bit v1, v2, v3, h1, h2;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); bits.delete(); m_sda = 1;
      v1 = 0; v2 = 0; v3 = 0; h1 = 0; h2 = 0;
    end else begin
      bit tick, took;
      int pre;
      byte unsigned b, pd;
      tick = v2 && !v3 && h2;
      pre  = q.size();
      took = (wr_en || (autoload_en && mbuf_rd));
      pd   = wr_en ? wr_data : mbuf_data;
      if (tick) begin
        if (bits.size() > 0) m_sda = bits.pop_front();
        else if (pre > 0) begin
          b = q.pop_front();
          m_sda = b[7];
          for (int i = 6; i >= 0; i--) bits.push_back(b[i]);
          bits.push_back(1'b1);
        end else m_sda = 1;
      end
      if (took && pre < 8) q.push_back(pd);
      v3 = v2; v2 = v1; v1 = vsync_in;
      h2 = h1; h1 = host_clk_in;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R3/R4/R10/R11/R12 sda_out", sda_out, m_sda);
      chk("R5/R7 low_flag", low_flag, q.size() < (int'(low_sel) + 1));
      chk("R6/R9 high_flag", high_flag, q.size() > 7);
      chk("R8 low_irq", low_irq, (q.size() < (int'(low_sel) + 1)) && low_irq_en);
    end
  end

  task automatic push(input byte unsigned b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic mread(input byte unsigned b);
    @(negedge clk); mbuf_rd = 1; mbuf_data = b;
    @(negedge clk); mbuf_rd = 0;
  endtask

  task automatic vs_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); vsync_in = 1;
      repeat (3) @(negedge clk);
      vsync_in = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sda_out", sda_out, 1);
    chk("R1 low_flag", low_flag, 1);
    chk("R1 high_flag", high_flag, 0);
    chk("R1 low_irq", low_irq, 0);
    rst_n = 1;
    low_irq_en = 1;
    @(negedge clk);
    chk("R1 low_irq enabled", low_irq, 1);

    // R3/R12: three bytes then idle (R4)
    host_clk_in = 1;
    push(8'hA5); push(8'h3C); push(8'hF0);
    vs_edges(30);

    // R2: host clock low, edges ignored
    host_clk_in = 0;
    push(8'h81);
    vs_edges(5);
    chk("R2 byte still queued", low_flag, 0);
    host_clk_in = 1;
    vs_edges(12);

    // R6/R9: overfill, ninth byte dropped
    for (int i = 0; i < 9; i++) push(byte'(8'h10 + i * 8'h11));
    @(negedge clk);
    chk("R9 full", high_flag, 1);
    for (int s = 0; s < 4; s++) begin
      low_sel = 2'(s);
      vs_edges(18);
    end
    low_irq_en = 0;
    vs_edges(40);

    // R10: auto-load on and off, R11 collision
    low_sel = 2'd3; low_irq_en = 1;
    mread(8'h55);
    @(negedge clk);
    chk("R10 read ignored when off", low_flag, 1);
    autoload_en = 1;
    mread(8'hC3); mread(8'h7E);
    @(negedge clk); wr_en = 1; wr_data = 8'h96; mbuf_rd = 1; mbuf_data = 8'h0F;
    @(negedge clk); wr_en = 0; mbuf_rd = 0;
    @(negedge clk);
    chk("R10/R11 three queued", low_flag, 1);
    mread(8'h42);
    @(negedge clk);
    chk("R10 four queued", low_flag, 0);
    vs_edges(45);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule